// File: doc/BRIEF.md
# Grouped-Priority Vectored Interrupt Controller

This block collects six interrupt request lines into a request register. It masks each request individually and also through one global enable bit, and it picks a single winner among the requests that are still live. The winner is chosen in three steps. The six lines are split into three fixed pairs. One swap bit per pair decides which member of that pair wins. A three-bit order code then ranks the three pairs against each other. The winner is offered to the CPU sequencer as a grant. The grant carries the request index and the program address of that request's two-byte vector slot.

Software reads and writes the request, mask and priority registers through a simple register port. Because a masked request is still latched, software can poll the request register instead of taking interrupts. Three strobes from the instruction decoder control the global enable: enable-interrupt, disable-interrupt and return-from-interrupt. When the sequencer acknowledges a grant, the block clears the served request and the global enable, so that no nested grant follows until a return or enable strobe.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A one-cycle high on `req_pulse[n]` sets request bit n, and the new value is readable at address 0 in the next cycle. Request register bits 7:6 always read 0, even after a write of 0xFF.
- R2: When a hardware request pulse on bit n arrives in the same cycle as a software write to the request register, bit n ends up set. The same holds when the pulse arrives in the same cycle as an acknowledge that clears bit n.
- R3: A request whose mask bit (address 1, bits 5:0, 1 = enabled) is 0 is still latched and readable at address 0, and it is never granted.
- R4: Mask bit 7 is the global enable. While it is 0, `grant_valid` stays low. Mask bit 6 always reads 0.
- R5: Each pair has a swap bit in the priority register (address 2). Pair A holds requests 3 and 5 and uses bit 5. Pair B holds requests 0 and 2 and uses bit 2. Pair C holds requests 1 and 4 and uses bit 1. A swap bit of 0 makes request 5, 2 or 1 win within its pair. A swap bit of 1 makes request 3, 0 or 4 win.
- R6: The pair order code is formed from priority bits {4,3,0}, with bit 4 as the most significant. The codes rank the pairs as follows: 001 C>A>B, 010 A>B>C, 011 A>C>B, 100 B>C>A, 101 C>B>A, 110 B>A>C. The winner is the enabled request in the highest-ranked pair that has one live request or more. Priority bits 7:6 read 0.
- R7: While the order code is 000 or 111, `grant_valid` stays low.
- R8: An `ack` in a cycle with `grant_valid` high clears the granted request bit and mask bit 7 on that clock edge. An `ack` while `grant_valid` is low changes nothing.
- R9: `ei_strobe` and `reti_strobe` set mask bit 7. `di_strobe` clears it and wins over both of them.
- R10: `grant_vec_addr` equals twice `grant_idx`. This is the address of the upper vector byte, and the lower byte follows at the next address.
- R11: After reset, all three registers read 0 and `grant_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 request, 1 mask, 2 priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| req_pulse | input | 6 | Request set pulses, one per source |
| ack | input | 1 | Sequencer accepts the current grant |
| ei_strobe | input | 1 | Enable-interrupt instruction strobe |
| di_strobe | input | 1 | Disable-interrupt instruction strobe |
| reti_strobe | input | 1 | Return-from-interrupt strobe |
| grant_valid | output | 1 | A request is granted |
| grant_idx | output | 3 | Index of the granted request |
| grant_vec_addr | output | VEC_AW | Program address of the vector slot |

## Verification
A wrong swap bit or a wrong entry in the order table shows up on `grant_idx` within one cycle of the priority write, because the grant is decoded from the registers directly. The stimulus table therefore covers every valid order code and every swap bit with sparse request patterns. Sparse patterns make a wrong ranking of an empty pair visible. A lost clear or a lost set in the request register only becomes visible at the next register read or the next grant. For that reason, each acknowledge and each same-cycle collision is followed at once by a read of the request and mask registers.

// File: rtl/grp_irq_pkg.sv
// Shared constants, types and decode functions of the grouped interrupt controller.
// Assumes six sources split into three fixed pairs.
package grp_irq_pkg;
    localparam int unsigned NUM_IRQ = 6;
    localparam int unsigned NUM_GRP = 3;
    localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
    localparam int unsigned GRP_W   = $clog2(NUM_GRP + 1);

    typedef logic [IDX_W-1:0] irq_idx_t;
    typedef logic [GRP_W-1:0] grp_id_t;

    // Register addresses
    localparam logic [1:0] ADDR_REQ  = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_PRIO = 2'd2;

    // Group ids: A=0, B=1, C=2
    localparam grp_id_t GRP_A = 2'd0;
    localparam grp_id_t GRP_B = 2'd1;
    localparam grp_id_t GRP_C = 2'd2;

    // Member that wins a pair while its swap bit is 0
    function automatic int unsigned pair_first(input int unsigned g);
        case (g)
            0:       return 5;
            1:       return 2;
            default: return 1;
        endcase
    endfunction

    // Member that wins a pair while its swap bit is 1
    function automatic int unsigned pair_second(input int unsigned g);
        case (g)
            0:       return 3;
            1:       return 0;
            default: return 4;
        endcase
    endfunction

    // Group ranking {highest, middle, lowest} for an order code
    function automatic logic [3*GRP_W-1:0] group_order(input logic [2:0] code);
        case (code)
            3'b001:  return {GRP_C, GRP_A, GRP_B};
            3'b010:  return {GRP_A, GRP_B, GRP_C};
            3'b011:  return {GRP_A, GRP_C, GRP_B};
            3'b100:  return {GRP_B, GRP_C, GRP_A};
            3'b101:  return {GRP_C, GRP_B, GRP_A};
            3'b110:  return {GRP_B, GRP_A, GRP_C};
            default: return {GRP_A, GRP_B, GRP_C};
        endcase
    endfunction
endpackage

// File: rtl/grp_irq_regs.sv
// Register set of the controller: request latch, mask with global enable, priority.
// Assumes one write port and a combinational read port. Same-cycle precedence:
// hardware set > ack clear > software write for requests; for the global enable
// ack clear > di > ei/reti > software write.
module grp_irq_regs
    import grp_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_IRQ-1:0] req_pulse,
    input  logic               take,
    input  irq_idx_t           take_idx,
    input  logic               ei_strobe,
    input  logic               di_strobe,
    input  logic               reti_strobe,
    output logic [NUM_IRQ-1:0] req_q,
    output logic [NUM_IRQ-1:0] en_q,
    output logic               gie_q,
    output logic [5:0]         prio_q
);
    logic [NUM_IRQ-1:0] req_d;
    logic [NUM_IRQ-1:0] en_d;
    logic               gie_d;
    logic [5:0]         prio_d;

    // Next request state: write, then ack clear, then hardware set on top
    always_comb begin
        req_d = req_q;
        if (reg_wr_en && reg_addr == ADDR_REQ)
            req_d = reg_wdata[NUM_IRQ-1:0];
        if (take)
            req_d[take_idx] = 1'b0;
        req_d = req_d | req_pulse;
    end

    // Next mask and global enable state
    always_comb begin
        en_d  = en_q;
        gie_d = gie_q;
        if (reg_wr_en && reg_addr == ADDR_MASK) begin
            en_d  = reg_wdata[NUM_IRQ-1:0];
            gie_d = reg_wdata[7];
        end
        if (ei_strobe || reti_strobe)
            gie_d = 1'b1;
        if (di_strobe)
            gie_d = 1'b0;
        if (take)
            gie_d = 1'b0;
    end

    // Next priority state
    always_comb begin
        prio_d = prio_q;
        if (reg_wr_en && reg_addr == ADDR_PRIO)
            prio_d = reg_wdata[5:0];
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            en_q   <= '0;
            gie_q  <= 1'b0;
            prio_q <= '0;
        end else begin
            req_q  <= req_d;
            en_q   <= en_d;
            gie_q  <= gie_d;
            prio_q <= prio_d;
        end
    end

    // Read mux; reserved bits read zero
    always_comb begin
        case (reg_addr)
            ADDR_REQ:  reg_rdata = {2'b00, req_q};
            ADDR_MASK: reg_rdata = {gie_q, 1'b0, en_q};
            ADDR_PRIO: reg_rdata = {2'b00, prio_q};
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/grp_irq_pair.sv
// Picks the winner of one request pair. FIRST wins while swap is 0, SECOND wins
// while swap is 1; a lone live member always wins. Purely combinational.
module grp_irq_pair
    import grp_irq_pkg::*;
#(
    parameter int unsigned FIRST  = 0,
    parameter int unsigned SECOND = 1
) (
    input  logic [NUM_IRQ-1:0] live,
    input  logic               swap,
    output logic               valid,
    output irq_idx_t           idx
);
    // Pair arbitration
    always_comb begin
        valid = live[FIRST] | live[SECOND];
        if (swap)
            idx = live[SECOND] ? irq_idx_t'(SECOND) : irq_idx_t'(FIRST);
        else
            idx = live[FIRST] ? irq_idx_t'(FIRST) : irq_idx_t'(SECOND);
    end
endmodule

// File: rtl/grp_irq_rank.sv
// Ranks the three pair winners by the order code and emits the overall winner.
// Reserved codes (000, 111) suppress the result. Purely combinational.
module grp_irq_rank
    import grp_irq_pkg::*;
(
    input  logic [NUM_GRP-1:0] grp_valid,
    input  irq_idx_t           grp_idx [NUM_GRP],
    input  logic [2:0]         code,
    output logic               valid,
    output irq_idx_t           idx
);
    logic [3*GRP_W-1:0] order;
    logic               code_ok;

    // Decode the order code
    always_comb begin
        order   = group_order(code);
        code_ok = (code != 3'b000) && (code != 3'b111);
    end

    // Walk from lowest to highest rank so the highest live group is kept
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int p = 0; p < NUM_GRP; p++) begin
            if (grp_valid[order[p*GRP_W +: GRP_W]]) begin
                valid = code_ok;
                idx   = grp_idx[order[p*GRP_W +: GRP_W]];
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
// Top of the grouped-priority vectored interrupt controller. Combines the
// register set, three pair arbiters and the group ranker. The grant is decoded
// combinationally from registered state, so it follows a request by one cycle.
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int unsigned VEC_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [5:0]         req_pulse,
    input  logic               ack,
    input  logic               ei_strobe,
    input  logic               di_strobe,
    input  logic               reti_strobe,
    output logic               grant_valid,
    output logic [2:0]         grant_idx,
    output logic [VEC_AW-1:0]  grant_vec_addr
);
    logic [NUM_IRQ-1:0] req_q;
    logic [NUM_IRQ-1:0] en_q;
    logic               gie_q;
    logic [5:0]         prio_q;
    logic [NUM_IRQ-1:0] live;
    logic [NUM_GRP-1:0] swap;
    logic [NUM_GRP-1:0] grp_valid;
    irq_idx_t           grp_idx [NUM_GRP];
    logic [2:0]         code;
    logic               win_valid;
    irq_idx_t           win_idx;
    logic               take;

    assign take = ack && grant_valid;

    grp_irq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .req_pulse   (req_pulse),
        .take        (take),
        .take_idx    (win_idx),
        .ei_strobe   (ei_strobe),
        .di_strobe   (di_strobe),
        .reti_strobe (reti_strobe),
        .req_q       (req_q),
        .en_q        (en_q),
        .gie_q       (gie_q),
        .prio_q      (prio_q)
    );

    // Field extraction from the priority register and gating of requests
    always_comb begin
        live    = req_q & en_q & {NUM_IRQ{gie_q}};
        swap[0] = prio_q[5];
        swap[1] = prio_q[2];
        swap[2] = prio_q[1];
        code    = {prio_q[4], prio_q[3], prio_q[0]};
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        grp_irq_pair #(
            .FIRST  (pair_first(g)),
            .SECOND (pair_second(g))
        ) u_pair (
            .live  (live),
            .swap  (swap[g]),
            .valid (grp_valid[g]),
            .idx   (grp_idx[g])
        );
    end

    grp_irq_rank u_rank (
        .grp_valid (grp_valid),
        .grp_idx   (grp_idx),
        .code      (code),
        .valid     (win_valid),
        .idx       (win_idx)
    );

    // Grant outputs and vector slot address (two bytes per vector)
    always_comb begin
        grant_valid    = win_valid;
        grant_idx      = win_idx;
        grant_vec_addr = {{(VEC_AW-IDX_W-1){1'b0}}, win_idx, 1'b0};
    end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
// Assertion checker for grp_irq_ctrl, attached by bind. Observes ports and the
// register state; drives nothing.
module grp_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] req_pulse,
    input logic       ack,
    input logic       ei_strobe,
    input logic       di_strobe,
    input logic       reti_strobe,
    input logic       grant_valid,
    input logic [2:0] grant_idx,
    input logic [5:0] req_q,
    input logic [5:0] en_q,
    input logic       gie_q,
    input logic [5:0] prio_q
);
    // R1
    pulse_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_pulse) |=> ((req_q & $past(req_pulse)) == $past(req_pulse)));

    // R3
    grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (req_q[grant_idx] && en_q[grant_idx]));

    // R4
    grant_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> gie_q);

    // R7
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({prio_q[4], prio_q[3], prio_q[0]} == 3'b000 ||
         {prio_q[4], prio_q[3], prio_q[0]} == 3'b111) |-> !grant_valid);

    // R8
    ack_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && grant_valid) |=> (!gie_q && !grant_valid));

    // R9
    di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_strobe |=> !gie_q);

    // R9
    reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_strobe && !di_strobe && !(ack && grant_valid)) |=> gie_q);
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pulse   (req_pulse),
    .ack         (ack),
    .ei_strobe   (ei_strobe),
    .di_strobe   (di_strobe),
    .reti_strobe (reti_strobe),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .req_q       (req_q),
    .en_q        (en_q),
    .gie_q       (gie_q),
    .prio_q      (prio_q)
);

// File: tb/grp_irq_ctrl_tb.sv
// Self-checking bench: a vector table of priority/request/mask settings with the
// expected grant, then directed tests for reset, collisions, ack and strobes.
module grp_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [5:0]  req_pulse = 6'h00;
    logic        ack = 1'b0;
    logic        ei_strobe = 1'b0;
    logic        di_strobe = 1'b0;
    logic        reti_strobe = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_idx;
    logic [15:0] grant_vec_addr;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    grp_irq_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr_en      (reg_wr_en),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .req_pulse      (req_pulse),
        .ack            (ack),
        .ei_strobe      (ei_strobe),
        .di_strobe      (di_strobe),
        .reti_strobe    (reti_strobe),
        .grant_valid    (grant_valid),
        .grant_idx      (grant_idx),
        .grant_vec_addr (grant_vec_addr)
    );

    // {prio, req, mask, exp_valid(4b), exp_idx(4b)}
    localparam int NV = 16;
    localparam logic [31:0] VECS [NV] = '{
        {8'h08, 8'h3F, 8'hBF, 4'd1, 4'd5},  // R6 A>B>C, R5 A default
        {8'h28, 8'h3F, 8'hBF, 4'd1, 4'd3},  // R5 A swapped
        {8'h01, 8'h3F, 8'hBF, 4'd1, 4'd1},  // R6 C>A>B
        {8'h03, 8'h3F, 8'hBF, 4'd1, 4'd4},  // R5 C swapped
        {8'h10, 8'h3F, 8'hBF, 4'd1, 4'd2},  // R6 B>C>A
        {8'h14, 8'h3F, 8'hBF, 4'd1, 4'd0},  // R5 B swapped
        {8'h11, 8'h05, 8'hBF, 4'd1, 4'd2},  // R6 C>B>A, C empty
        {8'h18, 8'h12, 8'hBF, 4'd1, 4'd1},  // R6 B>A>C, only C live
        {8'h09, 8'h13, 8'hBF, 4'd1, 4'd1},  // R6 A>C>B, A empty
        {8'h19, 8'h3F, 8'hBF, 4'd0, 4'd0},  // R7 code 111
        {8'h00, 8'h3F, 8'hBF, 4'd0, 4'd0},  // R7 code 000
        {8'h08, 8'h3F, 8'h3F, 4'd0, 4'd0},  // R4 global off
        {8'h08, 8'h3F, 8'h9F, 4'd1, 4'd3},  // R3 IRQ5 masked
        {8'h18, 8'h3F, 8'hBA, 4'd1, 4'd5},  // R3 pair B masked
        {8'h01, 8'h08, 8'hBF, 4'd1, 4'd3},  // R6 C>A>B, only IRQ3
        {8'h0B, 8'h12, 8'hBF, 4'd1, 4'd4}   // R6 A>C>B, C swapped
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic pulse(input logic [5:0] p);
        @(negedge clk);
        req_pulse = p;
        @(negedge clk);
        req_pulse = 6'h00;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        rd(2'd0, 8'h00, "R11 req");
        rd(2'd1, 8'h00, "R11 mask");
        rd(2'd2, 8'h00, "R11 prio");
        check("R11 grant_valid", int'(grant_valid), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd2, VECS[i][31:24]);
            wr(2'd0, VECS[i][23:16]);
            wr(2'd1, VECS[i][15:8]);
            check("R5/R6/R7 grant_valid", int'(grant_valid), int'(VECS[i][7:4]));
            if (VECS[i][7:4] != 4'd0) begin
                check("R5/R6 grant_idx", int'(grant_idx), int'(VECS[i][3:0]));
                // R10 vector slot address
                check("R10 vec_addr", int'(grant_vec_addr), 2 * int'(VECS[i][3:0]));
            end
        end

        // R1 pulse latch and reserved bits
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        pulse(6'h04);
        rd(2'd0, 8'h04, "R1 pulse latched");
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h3F, "R1 reserved bits");

        // R4 mask bit 6 and R6 priority reserved bits
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'hBF, "R4 mask bit6");
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h3F, "R6 prio bits 7:6");

        // R3 masked requests still latch
        wr(2'd1, 8'h80);
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h00);
        pulse(6'h3F);
        rd(2'd0, 8'h3F, "R3 masked latch");
        check("R3 no grant", int'(grant_valid), 0);

        // R2 hardware set beats software write
        wr(2'd0, 8'h01);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; req_pulse = 6'h02;
        @(negedge clk);
        reg_wr_en = 1'b0; req_pulse = 6'h00;
        rd(2'd0, 8'h02, "R2 set beats write");

        // R2 hardware set beats ack clear
        wr(2'd1, 8'hBF);
        check("R2 grant idx1", int'(grant_idx), 1);
        @(negedge clk);
        ack = 1'b1; req_pulse = 6'h02;
        @(negedge clk);
        ack = 1'b0; req_pulse = 6'h00;
        rd(2'd0, 8'h02, "R2 set beats ack");
        rd(2'd1, 8'h3F, "R8 ack clears gie");

        // R8 ack clears granted bit and global enable
        wr(2'd1, 8'hBF);
        wr(2'd0, 8'h3F);
        check("R8 grant idx5", int'(grant_idx), 5);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rd(2'd0, 8'h1F, "R8 bit cleared");
        rd(2'd1, 8'h3F, "R8 gie cleared");
        check("R8 no grant after ack", int'(grant_valid), 0);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rd(2'd0, 8'h1F, "R8 idle ack ignored");

        // R9 strobes
        @(negedge clk);
        ei_strobe = 1'b1;
        @(negedge clk);
        ei_strobe = 1'b0;
        rd(2'd1, 8'hBF, "R9 ei sets");
        check("R9 grant after ei", int'(grant_idx), 3);
        @(negedge clk);
        di_strobe = 1'b1; ei_strobe = 1'b1;
        @(negedge clk);
        di_strobe = 1'b0; ei_strobe = 1'b0;
        rd(2'd1, 8'h3F, "R9 di wins");
        check("R9 no grant after di", int'(grant_valid), 0);
        @(negedge clk);
        reti_strobe = 1'b1;
        @(negedge clk);
        reti_strobe = 1'b0;
        rd(2'd1, 8'hBF, "R9 reti sets");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule